// File: doc/BRIEF.md
# JTAG Instruction Register and Data-Path Select

This block holds the 6-bit test instruction of a boundary-scan port. A separate TAP state machine supplies one-cycle strobes for capture, shift and update of the instruction and data paths. The block shifts new opcodes in from TDI and loads them into a held instruction on the update strobe. It decodes the held instruction into mode signals for the boundary cells. It also chooses which data register feeds TDO during a data scan: the external boundary chain, a 32-bit identification register or a 1-bit bypass stage. The identification and bypass registers are inside the block.

The serial path is a strobe-driven shift chain clocked by TCK. It has no valid/ready handshake and no back-pressure, because the TAP sets the scan pace one bit per strobed cycle. The mode outputs are plain level signals. At most one strobe is active in any cycle. The test-logic-reset input is synchronous and takes priority over every strobe.

Top module: `jtag_ir_ctl`

## Requirements
- R1: In a cycle with `cap_ir` high, the instruction shift stage loads 101101, so the first six bits seen on TDO in the following IR shift are, in order, 1,0,1,1,0,1.
- R2: Each `shift_ir` cycle moves the shift stage one place toward bit 0 and puts TDI into bit 5. While `shift_ir` is high, TDO shows bit 0 of the shift stage. A 6-bit value shifted in therefore appears on TDO, LSB first, after the six captured bits.
- R3: The held instruction `ir_cur` changes only in a cycle with `upd_ir` high, where it takes the shift stage value. Capturing or shifting alone leaves it and all mode outputs unchanged.
- R4: A cycle with `tlr` high sets `ir_cur` to IDCODE (000010), whatever other strobes are present.
- R5: With IDCODE held, `cap_dr` loads the identification value {VERSION[3:0], PART[15:0], MFR[10:0], 1}, and the `shift_dr` cycles that follow present it on TDO LSB first, so the first bit out is 1.
- R6: With BYPASS (111111) held, `cap_dr` clears the 1-bit bypass stage, and each `shift_dr` cycle delays TDI by one bit. The TDO sequence is therefore 0 followed by the TDI bits.
- R7: Every opcode outside the defined set (for example 101010 and 000100) selects the bypass stage, and all mode outputs stay low.
- R8: EXTEST (000000), SAMPLE/PRELOAD (000001), pulse-train AC test (111100) and single-pulse AC test (111101) raise `bsr_sel` and route `bsr_tdo` to TDO outside IR shifting.
- R9: `pin_ctl` is high for EXTEST, both AC tests and CLAMP (111110). `pin_hiz` is high only for HIGHZ (000011). `ac_train` is high only for 111100, and `ac_pulse` only for 111101. `pin_ctl` and `pin_hiz` are never high together.
- R10: HIGHZ and CLAMP select the bypass stage as the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | Synchronous test-logic-reset, active high |
| cap_ir | input | 1 | Capture-IR strobe |
| shift_ir | input | 1 | Shift-IR strobe |
| upd_ir | input | 1 | Update-IR strobe |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| tdi | input | 1 | Serial test data in |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out |
| ir_cur | output | 6 | Held instruction |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| pin_ctl | output | 1 | Boundary cells drive the pins |
| pin_hiz | output | 1 | All outputs tri-stated |
| ac_train | output | 1 | Pulse-train AC test active |
| ac_pulse | output | 1 | Single-pulse AC test active |

## Verification
The hardest situation to reach is a partly shifted instruction. New opcode bits sit in the shift stage, but the held instruction must stay as it was. The stimulus captures and shifts a full opcode without the update strobe, checks `ir_cur` and the mode outputs, and only then issues the update. A second case shifts twelve bits with no update, so the captured pattern and then the injected opcode both come out on TDO. Test-logic-reset is also applied while a non-default instruction is held, and the identification value is read afterward.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;
  localparam int IR_W = 6;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 6'b000000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 6'b000001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 6'b000010;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 6'b000011;
  localparam logic [IR_W-1:0] OP_ACTRAIN = 6'b111100;
  localparam logic [IR_W-1:0] OP_ACPULSE = 6'b111101;
  localparam logic [IR_W-1:0] OP_CLAMP   = 6'b111110;
  localparam logic [IR_W-1:0] OP_BYPASS  = 6'b111111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 6'b101101;

  typedef enum logic [1:0] {
    DR_BYP = 2'd0,
    DR_ID  = 2'd1,
    DR_BSR = 2'd2
  } dr_sel_e;

  typedef struct packed {
    logic bsr_sel;
    logic pin_ctl;
    logic pin_hiz;
    logic ac_train;
    logic ac_pulse;
  } ir_mode_t;
endpackage

// File: rtl/jtag_ir_shift.sv
module jtag_ir_shift
  import jtag_ir_pkg::*;
(
  input  logic            tck,
  input  logic            tlr,
  input  logic            cap_ir,
  input  logic            shift_ir,
  input  logic            upd_ir,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_cur
);
  logic [IR_W-1:0] sh_q;

  always_ff @(posedge tck) begin
    if (tlr) begin
      sh_q   <= OP_IDCODE;
      ir_cur <= OP_IDCODE;
    end else begin
      if (cap_ir)        sh_q <= IR_CAPTURE;
      else if (shift_ir) sh_q <= {tdi, sh_q[IR_W-1:1]};
      if (upd_ir)        ir_cur <= sh_q;
    end
  end

  assign ir_lsb = sh_q[0];

  // R1
  cap_pattern_chk: assert property (@(posedge tck) disable iff (tlr)
    cap_ir |=> sh_q == IR_CAPTURE);
  // R2
  shift_in_chk: assert property (@(posedge tck) disable iff (tlr)
    (shift_ir && !cap_ir) |=> sh_q[IR_W-1] == $past(tdi));
  // R3
  hold_stable_chk: assert property (@(posedge tck) disable iff (tlr)
    !upd_ir |=> $stable(ir_cur));
  // R4
  reset_idcode_chk: assert property (@(posedge tck)
    tlr |=> ir_cur == OP_IDCODE);
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
  import jtag_ir_pkg::*;
(
  input  logic [IR_W-1:0] ir_cur,
  output dr_sel_e         dr_sel,
  output ir_mode_t        mode
);
  always_comb begin
    dr_sel = DR_BYP;
    mode   = '0;
    unique case (ir_cur)
      OP_EXTEST:  begin dr_sel = DR_BSR; mode.bsr_sel = 1'b1; mode.pin_ctl = 1'b1; end
      OP_SAMPLE:  begin dr_sel = DR_BSR; mode.bsr_sel = 1'b1; end
      OP_IDCODE:  dr_sel = DR_ID;
      OP_HIGHZ:   mode.pin_hiz = 1'b1;
      OP_ACTRAIN: begin dr_sel = DR_BSR; mode.bsr_sel = 1'b1; mode.pin_ctl = 1'b1;
                        mode.ac_train = 1'b1; end
      OP_ACPULSE: begin dr_sel = DR_BSR; mode.bsr_sel = 1'b1; mode.pin_ctl = 1'b1;
                        mode.ac_pulse = 1'b1; end
      OP_CLAMP:   mode.pin_ctl = 1'b1;
      default:    dr_sel = DR_BYP;
    endcase
  end

  // R9
  always_comb begin
    drive_vs_hiz_chk: assert (!(mode.pin_ctl && mode.pin_hiz));
  end
endmodule

// File: rtl/jtag_dr_regs.sv
module jtag_dr_regs
  import jtag_ir_pkg::*;
#(
  parameter logic [3:0]  VERSION = 4'h2,
  parameter logic [15:0] PART    = 16'h5A3C,
  parameter logic [10:0] MFR     = 11'h1D7
) (
  input  logic    tck,
  input  logic    tlr,
  input  logic    cap_dr,
  input  logic    shift_dr,
  input  logic    tdi,
  input  dr_sel_e dr_sel,
  output logic    byp_out,
  output logic    id_out
);
  localparam logic [ID_W-1:0] ID_VALUE = {VERSION, PART, MFR, 1'b1};

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck) begin
    if (tlr) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else begin
      if (dr_sel == DR_BYP) begin
        if (cap_dr)        byp_q <= 1'b0;
        else if (shift_dr) byp_q <= tdi;
      end
      if (dr_sel == DR_ID) begin
        if (cap_dr)        id_q <= ID_VALUE;
        else if (shift_dr) id_q <= {tdi, id_q[ID_W-1:1]};
      end
    end
  end

  assign byp_out = byp_q;
  assign id_out  = id_q[0];

  // R6
  byp_capture_chk: assert property (@(posedge tck) disable iff (tlr)
    (cap_dr && dr_sel == DR_BYP) |=> !byp_out);
  // R5
  id_capture_chk: assert property (@(posedge tck) disable iff (tlr)
    (cap_dr && dr_sel == DR_ID) |=> id_out);
endmodule

// File: rtl/jtag_ir_ctl.sv
module jtag_ir_ctl
  import jtag_ir_pkg::*;
#(
  parameter logic [3:0]  VERSION = 4'h2,
  parameter logic [15:0] PART    = 16'h5A3C,
  parameter logic [10:0] MFR     = 11'h1D7
) (
  input  logic       tck,
  input  logic       tlr,
  input  logic       cap_ir,
  input  logic       shift_ir,
  input  logic       upd_ir,
  input  logic       cap_dr,
  input  logic       shift_dr,
  input  logic       tdi,
  input  logic       bsr_tdo,
  output logic       tdo,
  output logic [5:0] ir_cur,
  output logic       bsr_sel,
  output logic       pin_ctl,
  output logic       pin_hiz,
  output logic       ac_train,
  output logic       ac_pulse
);
  logic     ir_lsb, byp_out, id_out;
  dr_sel_e  dr_sel;
  ir_mode_t mode;

  jtag_ir_shift u_shift (
    .tck(tck), .tlr(tlr), .cap_ir(cap_ir), .shift_ir(shift_ir),
    .upd_ir(upd_ir), .tdi(tdi), .ir_lsb(ir_lsb), .ir_cur(ir_cur)
  );

  jtag_ir_decode u_dec (
    .ir_cur(ir_cur), .dr_sel(dr_sel), .mode(mode)
  );

  jtag_dr_regs #(.VERSION(VERSION), .PART(PART), .MFR(MFR)) u_dr (
    .tck(tck), .tlr(tlr), .cap_dr(cap_dr), .shift_dr(shift_dr),
    .tdi(tdi), .dr_sel(dr_sel), .byp_out(byp_out), .id_out(id_out)
  );

  always_comb begin
    if (shift_ir) tdo = ir_lsb;
    else begin
      unique case (dr_sel)
        DR_ID:   tdo = id_out;
        DR_BSR:  tdo = bsr_tdo;
        default: tdo = byp_out;
      endcase
    end
  end

  assign bsr_sel  = mode.bsr_sel;
  assign pin_ctl  = mode.pin_ctl;
  assign pin_hiz  = mode.pin_hiz;
  assign ac_train = mode.ac_train;
  assign ac_pulse = mode.ac_pulse;

  // R3
  modes_hold_chk: assert property (@(posedge tck) disable iff (tlr)
    !upd_ir |=> $stable({bsr_sel, pin_ctl, pin_hiz, ac_train, ac_pulse}));
  // R9
  ac_exclusive_chk: assert property (@(posedge tck) disable iff (tlr)
    !(ac_train && ac_pulse));
endmodule

// File: tb/sim_jtag_ir_ctl.sv
module sim_jtag_ir_ctl;
  localparam logic [3:0]  VER  = 4'h2;
  localparam logic [15:0] PRT  = 16'h5A3C;
  localparam logic [10:0] MF   = 11'h1D7;
  localparam logic [31:0] IDV  = {VER, PRT, MF, 1'b1};

  logic tck = 0, tlr = 0, cap_ir = 0, shift_ir = 0, upd_ir = 0;
  logic cap_dr = 0, shift_dr = 0, tdi = 0, bsr_tdo = 0;
  logic tdo, bsr_sel, pin_ctl, pin_hiz, ac_train, ac_pulse;
  logic [5:0] ir_cur;
  int checks = 0, fails = 0;

  jtag_ir_ctl #(.VERSION(VER), .PART(PRT), .MFR(MF)) u0 (
    .tck(tck), .tlr(tlr), .cap_ir(cap_ir), .shift_ir(shift_ir), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .shift_dr(shift_dr), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .tdo(tdo), .ir_cur(ir_cur), .bsr_sel(bsr_sel), .pin_ctl(pin_ctl),
    .pin_hiz(pin_hiz), .ac_train(ac_train), .ac_pulse(ac_pulse)
  );

  always #5 tck = ~tck;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge tck);
  endtask

  task automatic do_reset();
    tick(); tlr = 1; tick(); tlr = 0;
  endtask

  // capture, shift n bits of val, optional update; returns bits seen on TDO
  task automatic ir_scan(input logic [11:0] val, input int n, input bit upd,
                         output logic [11:0] seen);
    seen = '0;
    tick(); cap_ir = 1; tick(); cap_ir = 0;
    for (int i = 0; i < n; i++) begin
      shift_ir = 1; tdi = val[i]; #1 seen[i] = tdo; tick();
    end
    shift_ir = 0;
    if (upd) begin upd_ir = 1; tick(); upd_ir = 0; end
  endtask

  task automatic dr_scan(input logic [31:0] val, input int n, output logic [31:0] seen);
    seen = '0;
    cap_dr = 1; tick(); cap_dr = 0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1; tdi = val[i]; #1 seen[i] = tdo; tick();
    end
    shift_dr = 0;
  endtask

  task automatic load(input logic [5:0] op);
    logic [11:0] s;
    ir_scan({6'b0, op}, 6, 1, s);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    do_reset();
    chk("R4 reset ir", ir_cur, 6'b000010);
    chk("R9 reset modes", {bsr_sel, pin_ctl, pin_hiz, ac_train, ac_pulse}, 0);
    dr_scan(0, 32, s);
    chk("R5 idcode after reset", s, IDV);
  endtask

  task automatic t_capture();
    logic [11:0] s;
    ir_scan(12'h03F, 6, 1, s);
    chk("R1 capture pattern", s[5:0], 6'b101101);
    chk("R3 updated", ir_cur, 6'b111111);
  endtask

  task automatic t_shift_through();
    logic [11:0] s;
    ir_scan({6'b100110, 6'b000000}, 12, 0, s);
    chk("R2 captured out", s[5:0], 6'b101101);
    chk("R2 injected out", s[11:6], 6'b000000);
    ir_scan({6'b0, 6'b110011}, 12, 0, s);
    chk("R2 opcode reappears", s[11:6], 6'b110011);
    chk("R3 no update keeps ir", ir_cur, 6'b111111);
  endtask

  task automatic t_hold();
    logic [11:0] s;
    load(6'b000010);
    ir_scan(12'h000, 6, 0, s);
    chk("R3 ir held pre-update", ir_cur, 6'b000010);
    chk("R3 modes held", {bsr_sel, pin_ctl}, 0);
    upd_ir = 1; tick(); upd_ir = 0;
    chk("R3 ir after update", ir_cur, 6'b000000);
    chk("R8 extest bsr_sel", bsr_sel, 1);
  endtask

  task automatic t_bypass(input logic [5:0] op, string req);
    logic [31:0] s;
    logic [7:0] pat = 8'b1011_0010;
    load(op);
    dr_scan({24'b0, pat}, 9, s);
    chk(req, s[8:0], {pat, 1'b0});
    chk(req, {bsr_sel, ac_train, ac_pulse}, 0);
  endtask

  task automatic t_modes();
    logic [5:0] ops [8] = '{6'b000000, 6'b000001, 6'b000010, 6'b000011,
                            6'b111100, 6'b111101, 6'b111110, 6'b101010};
    logic [4:0] exp [8] = '{5'b11000, 5'b10000, 5'b00000, 5'b00100,
                            5'b11010, 5'b11001, 5'b01000, 5'b00000};
    for (int i = 0; i < 8; i++) begin
      load(ops[i]);
      chk("R9 mode table", {bsr_sel, pin_ctl, pin_hiz, ac_train, ac_pulse}, exp[i]);
    end
  endtask

  task automatic t_bsr_route();
    logic [5:0] ops [4] = '{6'b000000, 6'b000001, 6'b111100, 6'b111101};
    for (int i = 0; i < 4; i++) begin
      load(ops[i]);
      bsr_tdo = 1; #1 chk("R8 route 1", tdo, 1);
      bsr_tdo = 0; #1 chk("R8 route 0", tdo, 0);
    end
  endtask

  task automatic t_tlr_mid();
    logic [31:0] s;
    load(6'b111110);
    tlr = 1; upd_ir = 1; tick(); tlr = 0; upd_ir = 0;
    chk("R4 tlr wins", ir_cur, 6'b000010);
    dr_scan(32'hFFFF_FFFF, 32, s);
    chk("R5 id scan", s, IDV);
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_capture();
    t_shift_through();
    t_hold();
    t_bypass(6'b111111, "R6 bypass delay");
    t_bypass(6'b101010, "R7 reserved 101010");
    t_bypass(6'b000100, "R7 reserved 000100");
    t_bypass(6'b000011, "R10 highz bypass");
    t_bypass(6'b111110, "R10 clamp bypass");
    t_modes();
    t_bsr_route();
    t_tlr_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule